// File: doc/BRIEF.md
# Programmable ROM Bus Mode Decoder

This block is a cycle-based, device-side model of the bus interface of a byte-wide, electrically programmable read-only memory. On each clock it decodes the active-low chip enable, the active-low output enable, a programming-voltage flag and an identifier-voltage flag into one operating mode. Depending on that mode it drives array data or a fixed identifier byte onto the output data lane, floats the lane, or folds the input byte into the addressed array location.

A host bench or a system-level model puts it where the memory part would sit. Separate data-in and data-out lanes and an output drive enable stand in for the bidirectional pins. The address width is a parameter. The default is kept small so that elaboration stays fast. Set it to 19 for the full 512K-byte space. The model has no analog thresholds and no supply-current modes.

Top module: `eprom_bus_if`

## Requirements
- R1: While reset is held and on the first cycle after it, `dout_en` is 0. Every array byte reads as FFh after reset.
- R2: With `vpp_hi`=0, `ce_n`=0, `oe_n`=0 and `id_hv`=0, the byte stored at `addr` appears on `dout` with `dout_en`=1 one clock edge later.
- R3: With `ce_n`=0 and `oe_n`=1, `dout_en` is 0 after the next edge.
- R4: With `ce_n`=1 and `vpp_hi`=0, `dout_en` is 0 after the next edge, whatever the value of `oe_n`.
- R5: In read mode with `id_hv`=1, `dout` is C2h when `addr[0]`=0 and C0h when `addr[0]`=1. In both cases `dout_en`=1 one edge later, and the array is not read.
- R6: With `vpp_hi`=1, `ce_n`=0 and `oe_n`=1, the clock edge writes `din` into the byte at `addr`, and the output floats.
- R7: With `vpp_hi`=1, `ce_n`=1 and `oe_n`=0, the array byte at `addr` is driven on `dout` with `dout_en`=1 one edge later.
- R8: With `vpp_hi`=1, `ce_n`=1 and `oe_n`=1, the output floats and the array does not change.
- R9: With `vpp_hi`=0, no combination of the other inputs alters any array byte.
- R10: A program operation stores the bitwise AND of the old byte and `din`, so no bit ever returns from 0 to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Model clock |
| rst_n | input | 1 | Synchronous active-low reset (power-up) |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| vpp_hi | input | 1 | Programming voltage present |
| id_hv | input | 1 | Identifier high voltage present on address bit 9 |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Data bus, input direction |
| dout | output | 8 | Data bus, output direction |
| dout_en | output | 1 | Output drive enable (0 = high impedance) |

## Verification
Mode decoding is combinational. `dout` and `dout_en` are registered, so every read, identifier, verify or float result belongs to the first rising edge after the inputs are applied. A program write lands on that same edge, and its effect can only be seen through a read on a later cycle, one more edge on. The bench drives inputs on the falling edge and samples on the next falling edge. Each check therefore sees exactly one register stage, and write effects are read back in a separate step.

// File: rtl/eprom_pkg.sv
// Shared types and constants for the programmable ROM bus model.
// Assumes byte-wide data; the identifier values are fixed by the part.
package eprom_pkg;
    localparam int DATA_W = 8;
    localparam logic [DATA_W-1:0] ID_MAKER  = 8'hC2;
    localparam logic [DATA_W-1:0] ID_DEVICE = 8'hC0;
    localparam logic [DATA_W-1:0] ERASED    = 8'hFF;

    typedef enum logic [2:0] {
        MD_READ    = 3'd0,
        MD_IDENT   = 3'd1,
        MD_DISABLE = 3'd2,
        MD_STANDBY = 3'd3,
        MD_PROGRAM = 3'd4,
        MD_VERIFY  = 3'd5,
        MD_INHIBIT = 3'd6
    } bus_mode_t;
endpackage

// File: rtl/eprom_mode_decode.sv
// Combinational decode of the control pins into one bus mode.
// Assumes the inputs are already synchronous to clk. Writes are
// enabled only in program mode, which needs the programming voltage.
module eprom_mode_decode
    import eprom_pkg::*;
(
    input  logic      ce_n,
    input  logic      oe_n,
    input  logic      vpp_hi,
    input  logic      id_hv,
    output bus_mode_t mode,
    output logic      wr_en,
    output logic      drive
);
    // Mode select from the pin truth table.
    always_comb begin
        if (!ce_n && !oe_n)
            mode = id_hv ? MD_IDENT : MD_READ;
        else if (!ce_n && oe_n)
            mode = vpp_hi ? MD_PROGRAM : MD_DISABLE;
        else if (vpp_hi && !oe_n)
            mode = MD_VERIFY;
        else if (vpp_hi)
            mode = MD_INHIBIT;
        else
            mode = MD_STANDBY;
    end

    // Strobes derived from the chosen mode.
    always_comb begin
        wr_en = (mode == MD_PROGRAM);
        drive = (mode == MD_READ) || (mode == MD_IDENT) || (mode == MD_VERIFY);
    end
endmodule

// File: rtl/eprom_array.sv
// Byte array model: combinational read, write that can only clear bits.
// Assumes wr_en is held for one clock per program pulse. On reset every
// byte returns to the erased value (model of a blank part at power-up).
module eprom_array
    import eprom_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Erase on reset; otherwise AND the program data into the byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= ERASED;
        end else if (wr_en) begin
            mem[addr] <= mem[addr] & wdata;
        end
    end

    // Asynchronous read of the addressed byte.
    always_comb rdata = mem[addr];

    AST_NO_BIT_SET: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((mem[$past(addr)] & ~$past(rdata)) == '0)); // R10
endmodule

// File: rtl/eprom_bus_if.sv
// Top of the programmable ROM bus model. It decodes the pins, picks the
// read source (array or identifier byte) and registers the output lane
// and its drive enable. Assumes a synchronous active-low power-up reset.
module eprom_bus_if
    import eprom_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              vpp_hi,
    input  logic              id_hv,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    output logic [7:0]        dout,
    output logic              dout_en
);
    bus_mode_t         mode;
    logic              wr_en;
    logic              drive;
    logic [DATA_W-1:0] arr_q;
    logic [DATA_W-1:0] sel_q;

    eprom_mode_decode u_dec (
        .ce_n   (ce_n),
        .oe_n   (oe_n),
        .vpp_hi (vpp_hi),
        .id_hv  (id_hv),
        .mode   (mode),
        .wr_en  (wr_en),
        .drive  (drive)
    );

    eprom_array #(.ADDR_W(ADDR_W)) u_arr (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .addr  (addr),
        .wdata (din),
        .rdata (arr_q)
    );

    // Read source: identifier byte chosen by address bit 0, else array.
    always_comb begin
        if (mode == MD_IDENT)
            sel_q = addr[0] ? ID_DEVICE : ID_MAKER;
        else
            sel_q = arr_q;
    end

    // Output register: data and drive enable, floated in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout    <= '0;
            dout_en <= 1'b0;
        end else begin
            dout    <= sel_q;
            dout_en <= drive;
        end
    end

    AST_WRITE_NEEDS_VPP: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (vpp_hi && !ce_n && oe_n)); // R9
    AST_STANDBY_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ce_n && !vpp_hi) |-> !dout_en); // R4
    AST_OE_HIGH_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(oe_n) |-> !dout_en); // R3
    AST_ID_MAKER: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && !ce_n && !oe_n && id_hv && !addr[0])
            |-> (dout_en && dout == 8'hC2)); // R5
endmodule

// File: tb/tb_eprom_bus_if.sv
module tb_eprom_bus_if;
    localparam int AW = 10;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          ce_n, oe_n, vpp_hi, id_hv;
    logic [AW-1:0] addr;
    logic [7:0]    din;
    logic [7:0]    dout;
    logic          dout_en;

    int n_chk = 0;
    int n_err = 0;

    eprom_bus_if #(.ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n),
        .vpp_hi(vpp_hi), .id_hv(id_hv), .addr(addr), .din(din),
        .dout(dout), .dout_en(dout_en)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Apply pins on a falling edge; sample after one rising edge.
    task automatic step(input logic ce, input logic oe, input logic vp,
                        input logic id, input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        ce_n = ce; oe_n = oe; vpp_hi = vp; id_hv = id; addr = a; din = d;
        @(negedge clk);
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [7:0] exp, input string req);
        step(1'b0, 1'b0, 1'b0, 1'b0, a, 8'h00);
        check(req, {dout_en, dout}, {1'b1, exp});
    endtask

    task automatic t_reset;
        rst_n = 1'b0; ce_n = 1'b0; oe_n = 1'b0; vpp_hi = 1'b0; id_hv = 1'b0;
        addr = '0; din = '0;
        repeat (3) @(negedge clk);
        check("R1 en in reset", {8'h00, dout_en}, 9'h0);
        rst_n = 1'b1;
        check("R1 en after reset", {8'h00, dout_en}, 9'h0);
        rd(10'h000, 8'hFF, "R1 erased low");
        rd(10'h3FF, 8'hFF, "R1 erased high");
    endtask

    task automatic t_program;
        step(1'b0, 1'b1, 1'b1, 1'b0, 10'h055, 8'hA5);
        check("R6 float while program", {8'h00, dout_en}, 9'h0);
        rd(10'h055, 8'hA5, "R2 read programmed");
        rd(10'h056, 8'hFF, "R2 neighbour untouched");
    endtask

    task automatic t_and;
        step(1'b0, 1'b1, 1'b1, 1'b0, 10'h055, 8'h5F);
        rd(10'h055, 8'h05, "R10 and of old and new");
        step(1'b0, 1'b1, 1'b1, 1'b0, 10'h055, 8'hFF);
        rd(10'h055, 8'h05, "R10 no bit returns to one");
    endtask

    task automatic t_lock;
        step(1'b0, 1'b1, 1'b0, 1'b0, 10'h100, 8'h00);
        check("R3 disable floats", {8'h00, dout_en}, 9'h0);
        step(1'b1, 1'b0, 1'b0, 1'b0, 10'h100, 8'h00);
        step(1'b1, 1'b1, 1'b0, 1'b0, 10'h100, 8'h00);
        rd(10'h100, 8'hFF, "R9 low vpp no write");
    endtask

    task automatic t_standby;
        step(1'b1, 1'b0, 1'b0, 1'b0, 10'h055, 8'h00);
        check("R4 standby oe low", {8'h00, dout_en}, 9'h0);
        step(1'b1, 1'b1, 1'b0, 1'b0, 10'h055, 8'h00);
        check("R4 standby oe high", {8'h00, dout_en}, 9'h0);
    endtask

    task automatic t_ident;
        step(1'b0, 1'b0, 1'b0, 1'b1, 10'h000, 8'h00);
        check("R5 maker code", {dout_en, dout}, {1'b1, 8'hC2});
        step(1'b0, 1'b0, 1'b0, 1'b1, 10'h001, 8'h00);
        check("R5 device code", {dout_en, dout}, {1'b1, 8'hC0});
        step(1'b0, 1'b0, 1'b0, 1'b1, 10'h054, 8'h00);
        check("R5 id ignores array", {dout_en, dout}, {1'b1, 8'hC2});
    endtask

    task automatic t_verify;
        step(1'b1, 1'b0, 1'b1, 1'b0, 10'h055, 8'h00);
        check("R7 verify drives array", {dout_en, dout}, {1'b1, 8'h05});
    endtask

    task automatic t_inhibit;
        step(1'b1, 1'b1, 1'b1, 1'b0, 10'h200, 8'h00);
        check("R8 inhibit floats", {8'h00, dout_en}, 9'h0);
        rd(10'h200, 8'hFF, "R8 inhibit no write");
    endtask

    initial begin
        t_reset;
        t_program;
        t_and;
        t_lock;
        t_standby;
        t_ident;
        t_verify;
        t_inhibit;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule